// File: doc/BRIEF.md
# Triangle Tone Channel

This block produces one voice of a tone generator: a stepped triangle wave built from a 32-step sequence that falls from 15 to 0 and then rises from 0 to 15. Software programs it through three byte-wide write strobes. The first write sets up the linear counter. The second sets the low byte of an 11-bit period. The third sets the period high bits and a length-table index. A separate strobe enables or disables the voice.

A free-running timer clock enable drives an 11-bit down-counter. Each time that counter reloads, the sequencer may take one step. It steps only when two gating counters are both non-zero. The first is a 7-bit linear counter, updated on quarter-frame strobes. The second is a length counter, updated on half-frame strobes. A single control bit stops the length counter. The same bit decides whether the linear counter keeps reloading.

The output is a 4-bit sample. It is computed combinationally from the registered step and the registered enable, so it changes in the cycle after the strobe that caused the change.

Top module: `tri_voice`

## Requirements
- R1: After a synchronous active-low reset, the channel is disabled and the sample reads 0. The sequence step is 0, so enabling the channel at once gives sample 15.
- R2: A control write (`wr_ctl`) stores data bits 6:0 as the linear reload value and data bit 7 as the control bit.
- R3: `wr_plo` sets period bits 7:0. `wr_phi` sets period bits 10:8 from data bits 2:0 and loads the timer counter at once with the new period. While a period P is in force, the sequencer may step once every P+1 timer ticks.
- R4: The sample is 15 minus the step for steps 0 to 15, and step minus 16 for steps 16 to 31. The step advances by exactly one per allowed step and wraps from 31 to 0.
- R5: The sequencer does not step while the linear counter is 0.
- R6: The sequencer does not step while the length counter is 0.
- R7: A quarter-frame strobe loads the linear counter with the reload value when the reload flag is set. Otherwise it decrements the counter if the counter is non-zero. `wr_phi` sets the reload flag. A quarter-frame strobe clears the flag only when the control bit is 0.
- R8: `wr_phi` loads the length counter from a 32-entry table indexed by data bits 7:3, but only when the channel is already enabled. Index 0 gives 10, index 1 gives 254 and index 3 gives 2.
- R9: A half-frame strobe decrements a non-zero length counter when the control bit is 0. When the control bit is 1 the length counter holds.
- R10: A disable strobe (`en_wr` with `en_val`=0) clears the length counter and forces the sample to 0 from the next cycle. Re-enabling does not restore the length count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_ctl | input | 1 | Strobe: write linear reload value and control bit |
| wr_plo | input | 1 | Strobe: write period low byte |
| wr_phi | input | 1 | Strobe: write period high bits and length index |
| wr_data | input | 8 | Byte written by any of the three strobes |
| en_wr | input | 1 | Strobe: update the channel enable |
| en_val | input | 1 | New enable value, taken when `en_wr` is high |
| tick | input | 1 | Timer clock enable |
| qtr | input | 1 | Quarter-frame strobe |
| half | input | 1 | Half-frame strobe |
| sample | output | 4 | Current 4-bit sample |

## Verification
The bench walks one full 32-step cycle plus the wrap. A mirrored or off-by-one table would show a wrong level at the turn between steps 15 and 16, or at the wrap.

It checks the period at two sizes, one of which uses the high bits. It also rewrites the high bits in mid-count; a timer that did not reload on that write would step early.

For the linear counter, the bench separates a load from a decrement. It also checks the two meanings of the control bit. A design that cleared the reload flag regardless of that bit would let the counter run down to 0 and halt. A design that never cleared the flag would reload and keep running after the counter had reached 0.

For the length counter, the bench loads it while disabled and then looks for a halt. A design that loaded it anyway would keep stepping. The bench also checks that the half-frame decrement stops while the control bit is set.

// File: rtl/tri_voice_pkg.sv
// Shared constants and lookup functions for the triangle tone channel.
// Assumes a 5-bit sequence step and a 4-bit sample.
package tri_voice_pkg;

    localparam int TRI_STEP_W   = 5;
    localparam int TRI_SAMPLE_W = 4;
    localparam int TRI_IDX_W    = 5;
    localparam int TRI_LEN_W    = 8;

    // Length-table lookup: 5-bit index to a count of half frames.
    function automatic logic [TRI_LEN_W-1:0] len_lookup(input logic [TRI_IDX_W-1:0] idx);
        logic [TRI_LEN_W-1:0] v;
        case (idx)
            5'd0:  v = 8'd10;   5'd1:  v = 8'd254;  5'd2:  v = 8'd20;   5'd3:  v = 8'd2;
            5'd4:  v = 8'd40;   5'd5:  v = 8'd4;    5'd6:  v = 8'd80;   5'd7:  v = 8'd6;
            5'd8:  v = 8'd160;  5'd9:  v = 8'd8;    5'd10: v = 8'd60;   5'd11: v = 8'd10;
            5'd12: v = 8'd14;   5'd13: v = 8'd12;   5'd14: v = 8'd26;   5'd15: v = 8'd14;
            5'd16: v = 8'd12;   5'd17: v = 8'd16;   5'd18: v = 8'd24;   5'd19: v = 8'd18;
            5'd20: v = 8'd48;   5'd21: v = 8'd20;   5'd22: v = 8'd96;   5'd23: v = 8'd22;
            5'd24: v = 8'd192;  5'd25: v = 8'd24;   5'd26: v = 8'd72;   5'd27: v = 8'd26;
            5'd28: v = 8'd16;   5'd29: v = 8'd28;   5'd30: v = 8'd32;   default: v = 8'd30;
        endcase
        return v;
    endfunction

    // Folded triangle: first half counts down, second half counts up.
    function automatic logic [TRI_SAMPLE_W-1:0] tri_level(input logic [TRI_STEP_W-1:0] step);
        return step[TRI_STEP_W-1] ? step[TRI_SAMPLE_W-1:0] : ~step[TRI_SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/tri_period_timer.sv
// Period register and down-counter. Emits reload_pulse on a tick that finds
// the counter at zero. A high-byte write reloads the counter at once.
// Assumes PERIOD_W > DATA_W.
module tri_period_timer #(
    parameter int PERIOD_W = 11,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] data,
    output logic              reload_pulse
);
    localparam int HI_W = PERIOD_W - DATA_W;

    logic [PERIOD_W-1:0] period_q, period_nx, cnt_q;

    // Merge byte writes into the next period value.
    always_comb begin
        period_nx = period_q;
        if (wr_lo) period_nx[DATA_W-1:0] = data;
        if (wr_hi) period_nx[PERIOD_W-1:DATA_W] = data[HI_W-1:0];
    end

    // Hold the programmed period.
    always_ff @(posedge clk) begin
        if (!rst_n) period_q <= '0;
        else        period_q <= period_nx;
    end

    // Count down on ticks; reload on expiry or on a high-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (wr_hi)             cnt_q <= period_nx;
        else if (tick && cnt_q == 0) cnt_q <= period_q;
        else if (tick)              cnt_q <= cnt_q - 1'b1;
    end

    assign reload_pulse = tick && (cnt_q == 0) && !wr_hi;
endmodule

// File: rtl/tri_linear_gate.sv
// Linear counter with its reload flag and control bit. It is updated on
// quarter-frame strobes. Assumes data bit LIN_W is the control bit.
module tri_linear_gate #(
    parameter int LIN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic             wr_hi,
    input  logic [LIN_W:0]   data,
    input  logic             qtr,
    output logic             ctrl,
    output logic             flag,
    output logic [LIN_W-1:0] reload_val,
    output logic [LIN_W-1:0] lin,
    output logic             nonzero
);
    // Capture the reload value and control bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
            ctrl       <= 1'b0;
        end else if (wr_ctl) begin
            reload_val <= data[LIN_W-1:0];
            ctrl       <= data[LIN_W];
        end
    end

    // Reload flag: set by a high-byte write, dropped after a quarter frame when control is 0.
    always_ff @(posedge clk) begin
        if (!rst_n)             flag <= 1'b0;
        else if (wr_hi)         flag <= 1'b1;
        else if (qtr && !ctrl)  flag <= 1'b0;
    end

    // Quarter-frame update of the linear counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              lin <= '0;
        else if (qtr && flag)    lin <= reload_val;
        else if (qtr && lin != 0) lin <= lin - 1'b1;
    end

    assign nonzero = (lin != 0);
endmodule

// File: rtl/tri_length_gate.sv
// Channel enable and length counter. The counter loads from the table only
// while the channel is enabled, is cleared by a disable, and counts down on
// half frames unless halted.
module tri_length_gate
    import tri_voice_pkg::*;
#(
    parameter int LEN_W = TRI_LEN_W,
    parameter int IDX_W = TRI_IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             load,
    input  logic [IDX_W-1:0] idx,
    input  logic             half,
    input  logic             halt,
    output logic             enabled,
    output logic [LEN_W-1:0] len,
    output logic             nonzero
);
    // Channel enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)     enabled <= 1'b0;
        else if (en_wr) enabled <= en_val;
    end

    // Length counter: disable clears, load when enabled, count down on half frames.
    always_ff @(posedge clk) begin
        if (!rst_n)                          len <= '0;
        else if (en_wr && !en_val)           len <= '0;
        else if (load && enabled)            len <= LEN_W'(len_lookup(TRI_IDX_W'(idx)));
        else if (half && !halt && len != 0)  len <= len - 1'b1;
    end

    assign nonzero = (len != 0);
endmodule

// File: rtl/tri_step_seq.sv
// 32-step sequencer and sample mapping. Steps on advance; the sample reads 0
// while the channel is disabled.
module tri_step_seq
    import tri_voice_pkg::*;
#(
    parameter int STEP_W   = TRI_STEP_W,
    parameter int SAMPLE_W = TRI_SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic                enabled,
    output logic [STEP_W-1:0]   step,
    output logic [SAMPLE_W-1:0] sample
);
    // Step position, wrapping naturally at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= '0;
        else if (advance) step <= step + 1'b1;
    end

    // Map the step to a level and gate it with the enable.
    always_comb begin
        sample = enabled ? SAMPLE_W'(tri_level(TRI_STEP_W'(step))) : '0;
    end
endmodule

// File: rtl/tri_voice.sv
// Triangle tone channel top. It decodes the three register strobes and joins
// the timer, the two gating counters and the sequencer.
// Assumes one-cycle strobes, all synchronous to clk.
module tri_voice #(
    parameter int DATA_W   = 8,
    parameter int PERIOD_W = 11,
    parameter int STEP_W   = 5,
    parameter int SAMPLE_W = 4,
    parameter int LEN_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctl,
    input  logic                wr_plo,
    input  logic                wr_phi,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                en_wr,
    input  logic                en_val,
    input  logic                tick,
    input  logic                qtr,
    input  logic                half,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int HI_W  = PERIOD_W - DATA_W;
    localparam int IDX_W = DATA_W - HI_W;
    localparam int LIN_W = DATA_W - 1;

    logic              reload_pulse;
    logic              ctrl_q, flag_q, lin_nz, len_nz, enabled_q, advance;
    logic [LIN_W-1:0]  rld_val_q, lin_q;
    logic [LEN_W-1:0]  len_q;
    logic [STEP_W-1:0] step_q;

    tri_period_timer #(.PERIOD_W(PERIOD_W), .DATA_W(DATA_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_plo), .wr_hi(wr_phi),
        .data(wr_data), .reload_pulse(reload_pulse)
    );

    tri_linear_gate #(.LIN_W(LIN_W)) u_lin (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_hi(wr_phi), .data(wr_data),
        .qtr(qtr), .ctrl(ctrl_q), .flag(flag_q), .reload_val(rld_val_q),
        .lin(lin_q), .nonzero(lin_nz)
    );

    tri_length_gate #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_len (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val), .load(wr_phi),
        .idx(wr_data[DATA_W-1:HI_W]), .half(half), .halt(ctrl_q),
        .enabled(enabled_q), .len(len_q), .nonzero(len_nz)
    );

    // Step only when the timer reloads and both gates are open.
    assign advance = reload_pulse && lin_nz && len_nz;

    tri_step_seq #(.STEP_W(STEP_W), .SAMPLE_W(SAMPLE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .advance(advance), .enabled(enabled_q),
        .step(step_q), .sample(sample)
    );
endmodule

// File: rtl/tri_voice_chk.sv
// Property checker for tri_voice, bound to the top and reading its internal state.
module tri_voice_chk #(
    parameter int STEP_W   = 5,
    parameter int SAMPLE_W = 4,
    parameter int LIN_W    = 7,
    parameter int LEN_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en_wr,
    input logic                en_val,
    input logic                wr_phi,
    input logic                qtr,
    input logic                half,
    input logic [SAMPLE_W-1:0] sample,
    input logic [STEP_W-1:0]   step,
    input logic [LIN_W-1:0]    lin,
    input logic [LIN_W-1:0]    reload_val,
    input logic                flag,
    input logic                ctrl,
    input logic [LEN_W-1:0]    len
);
    // R4
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step != $past(step)) |-> (step == STEP_W'($past(step) + 1'b1)));
    // R5
    lin_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lin == 0) |=> $stable(step));
    // R6
    len_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len == 0) |=> $stable(step));
    // R7
    lin_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr && flag) |=> (lin == $past(reload_val)));
    // R7
    lin_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr && !flag && lin != 0) |=> (lin == $past(lin) - 1'b1));
    // R9
    len_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half && !ctrl && len != 0 && !en_wr && !wr_phi) |=> (len == $past(len) - 1'b1));
    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_val) |=> (sample == 0 && len == 0));
endmodule

bind tri_voice tri_voice_chk #(
    .STEP_W(STEP_W), .SAMPLE_W(SAMPLE_W), .LIN_W(LIN_W), .LEN_W(LEN_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val), .wr_phi(wr_phi),
    .qtr(qtr), .half(half), .sample(sample), .step(step_q), .lin(lin_q),
    .reload_val(rld_val_q), .flag(flag_q), .ctrl(ctrl_q), .len(len_q)
);

// File: tb/tri_voice_tb.sv
// Directed bench for tri_voice: one task per scenario.
module tri_voice_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_ctl = 0, wr_plo = 0, wr_phi = 0, en_wr = 0, en_val = 0;
    logic       tick = 0, qtr = 0, half = 0;
    logic [7:0] wr_data = '0;
    logic [3:0] sample;

    int checks = 0;
    int fails  = 0;
    int bstep  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    tri_voice u_dut (
        .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_plo(wr_plo), .wr_phi(wr_phi),
        .wr_data(wr_data), .en_wr(en_wr), .en_val(en_val), .tick(tick), .qtr(qtr),
        .half(half), .sample(sample)
    );

    function automatic logic [3:0] lvl(input int s);
        int m = s % 32;
        return (m < 16) ? 4'(15 - m) : 4'(m - 16);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // sel: 0 control, 1 period low, 2 period high
    task automatic wr(input int sel, input logic [7:0] d);
        @(negedge clk);
        wr_data = d;
        wr_ctl = (sel == 0); wr_plo = (sel == 1); wr_phi = (sel == 2);
        @(negedge clk);
        wr_ctl = 0; wr_plo = 0; wr_phi = 0;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk); en_wr = 1; en_val = v;
        @(negedge clk); en_wr = 0;
    endtask

    task automatic do_qtr();
        @(negedge clk); qtr = 1;
        @(negedge clk); qtr = 0;
    endtask

    task automatic do_half();
        @(negedge clk); half = 1;
        @(negedge clk); half = 0;
    endtask

    // One timer tick; check whether the step moved as expected.
    task automatic tk(input bit adv, input string req);
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        if (adv) bstep++;
        chk(sample == lvl(bstep), req, sample, lvl(bstep));
    endtask

    // Put the channel in free-running state: period 0, linear and length held high.
    task automatic arm();
        wr(0, 8'hFF);
        wr(1, 8'h00);
        wr(2, 8'h08);
        do_qtr();
    endtask

    task automatic t_reset();
        chk(sample == 0, "R1 reset sample", sample, 0);
        set_en(1);
        chk(sample == 15, "R1 step zero after enable", sample, 15);
    endtask

    task automatic t_sequence();
        arm();
        for (int i = 0; i < 33; i++) tk(1, "R4 sequence");
    endtask

    task automatic t_period();
        wr(1, 8'h03); wr(2, 8'h08);
        for (int i = 0; i < 3; i++) tk(0, "R3 period 3 wait");
        tk(1, "R3 period 3 step");
        tk(0, "R3 mid count"); tk(0, "R3 mid count");
        wr(2, 8'h08);
        for (int i = 0; i < 3; i++) tk(0, "R3 reload on high write");
        tk(1, "R3 step after reload");
        wr(1, 8'h02); wr(2, 8'h09);
        for (int i = 0; i < 258; i++) tk(0, "R3 period 258 wait");
        tk(1, "R3 period 258 step");
        wr(1, 8'h00); wr(2, 8'h08);
        tk(1, "R3 period 0");
    endtask

    task automatic t_linear();
        wr(0, 8'h05); wr(2, 8'h08);
        do_qtr();
        for (int i = 0; i < 4; i++) begin
            do_qtr();
            tk(1, "R2 R7 linear counting down");
        end
        do_qtr();
        tk(0, "R5 linear zero halts");
        do_qtr();
        tk(0, "R7 flag cleared, no reload");
        wr(0, 8'h81); wr(2, 8'h08);
        do_qtr(); do_qtr();
        tk(1, "R7 R2 control keeps reloading");
        do_qtr();
        tk(1, "R7 control keeps reloading");
        arm();
    endtask

    task automatic t_length();
        wr(0, 8'h7F);
        wr(2, 8'h18);
        do_half();
        tk(1, "R9 length 1 still runs");
        do_half();
        tk(0, "R6 length zero halts");
        wr(2, 8'h00);
        for (int i = 0; i < 9; i++) do_half();
        tk(1, "R8 index 0 gives 10");
        do_half();
        tk(0, "R8 index 0 expires at 10");
        wr(0, 8'hFF); wr(2, 8'h18);
        do_half(); do_half(); do_half();
        tk(1, "R9 control holds length");
    endtask

    task automatic t_enable();
        set_en(0);
        chk(sample == 0, "R10 disabled sample", sample, 0);
        wr(2, 8'h08);
        set_en(1);
        chk(sample == lvl(bstep), "R10 level back after enable", sample, lvl(bstep));
        tk(0, "R8 R10 no load while disabled");
        wr(2, 8'h08);
        tk(1, "R8 load while enabled");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_sequence();
        t_period();
        t_linear();
        t_length();
        t_enable();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule